// File: doc/BRIEF.md
# USB Device Suspend/Resume Power Sequencer

This block controls the low-power states of a USB device. While the device runs, it watches the USB bus. After a fixed number of slow reference ticks with no bus activity it raises a one-cycle idle interrupt. It never suspends the device by itself. Firmware answers the interrupt, or its own inactivity policy, by pulsing a suspend request. The sequencer then stops the crystal oscillator and masks the internal clocks.

While suspended, the block waits for a wake event. Two wake sources exist, and each has its own enable. The first is USB bus activity. The second is any difference between the key inputs and a snapshot taken when the suspend began. A wake event moves the block into a resume phase. In that phase the oscillator runs again but the internal clocks stay masked for a programmable number of reference ticks. The block then returns to the running state by itself, with no firmware action.

The block moves no data, so all of its pins are plain control and status signals with no handshake. The bus-activity and key inputs pass through two-flop synchronizers inside the block. The reference tick is a one-cycle pulse in the block's own clock domain.

Top module: `usb_pwr_seq`

## Requirements
- R1: After reset the state code is 0 (running), `osc_en_o` = 1, `clk_en_o` = 1 and `idle_irq_o` = 0.
- R2: A one-cycle pulse on `susp_set_i` in the running state moves the block to state code 1 (suspended). In that state `osc_en_o` = 0 and `clk_en_o` = 0.
- R3: In the running state with the bus quiet, `idle_irq_o` pulses for exactly one cycle on the IDLE_TICKS-th tick (6 by default). It does not pulse again until bus activity is seen, and the state stays running.
- R4: Bus activity in the running state restarts the idle tick count from zero.
- R5: While suspended with `wake_usb_en_i` = 1, bus activity moves the block to state code 2 (resuming). With `wake_usb_en_i` = 0, bus activity leaves it suspended.
- R6: While suspended with `wake_key_en_i` = 1, a key input vector that differs from the snapshot taken at suspend entry moves the block to resuming. With `wake_key_en_i` = 0, or with unchanged keys, it stays suspended.
- R7: In the resuming state `osc_en_o` = 1 and `clk_en_o` = 0.
- R8: The resume phase lasts N = 1 + (f*19 + 7)/15 reference ticks (integer division), where f is `resume_len_i`. So f = 0 gives 1 tick and f = 15 gives 20 ticks. The block stays resuming after N-1 ticks and is running again after the N-th tick.
- R9: The pending suspend request clears on the return to the running state, so the block stays running after a resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| susp_set_i | input | 1 | Firmware suspend request pulse |
| wake_usb_en_i | input | 1 | Enables wake on bus activity |
| wake_key_en_i | input | 1 | Enables wake on key change |
| resume_len_i | input | 4 | Resume length code f |
| bus_act_i | input | 1 | USB bus activity (asynchronous) |
| key_i | input | KEY_W | Key inputs (asynchronous) |
| tick_i | input | 1 | Slow reference tick pulse |
| osc_en_o | output | 1 | Crystal oscillator enable |
| clk_en_o | output | 1 | Internal clock ungate |
| idle_irq_o | output | 1 | Bus idle interrupt pulse |
| state_o | output | 2 | 0 running, 1 suspended, 2 resuming |

## Verification
The bench uses the default parameters: IDLE_TICKS = 6, resume ticks ranging from 1 to 20, and eight key inputs. It supplies the reference tick as a pulse every three clocks, so millisecond-scale windows shrink to a few dozen cycles. This puts the whole 1-to-20 resume range, both ends of it, and the exact idle threshold within reach. Random resume codes, wake sources and flipped key bits are mixed with directed cases: disabled sources, unchanged keys, and a restart of the idle count.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_SLEEP = 2'd1,
    PS_WAKE  = 2'd2
  } pwr_state_e;

  // Linear map of the code f onto [minv, maxv] ticks, rounded to nearest.
  function automatic int res_ticks(input int f, input int minv,
                                   input int maxv, input int fw);
    int fmax;
    fmax = (1 << fw) - 1;
    return minv + (f * (maxv - minv) + fmax / 2) / fmax;
  endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pwr_idle_det.sv
module pwr_idle_det #(
  parameter int IDLE_TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic act_i,
  input  logic tick_i,
  output logic irq_o
);
  localparam int IW = $clog2(IDLE_TICKS + 1);
  localparam logic [IW-1:0] LAST = IW'(IDLE_TICKS - 1);
  localparam logic [IW-1:0] SAT  = IW'(IDLE_TICKS);

  logic [IW-1:0] cnt_q;
  logic          irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= en_i && !act_i && tick_i && (cnt_q == LAST);
      if (!en_i || act_i)
        cnt_q <= '0;
      else if (tick_i && cnt_q != SAT)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign irq_o = irq_q;

  a_r4_act_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && act_i) |=> (cnt_q == '0));
  a_r3_irq_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(en_i));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
endmodule

// File: rtl/pwr_resume_timer.sv
module pwr_resume_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!en_i)
      cnt_q <= '0;
    else if (tick_i)
      cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && tick_i && (cnt_q == len_i - 1'b1);

  a_r8_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q < len_i));
endmodule

// File: rtl/usb_pwr_seq.sv
module usb_pwr_seq #(
  parameter int KEY_W      = 8,
  parameter int RES_W      = 4,
  parameter int RES_MIN    = 1,
  parameter int RES_MAX    = 20,
  parameter int IDLE_TICKS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             susp_set_i,
  input  logic             wake_usb_en_i,
  input  logic             wake_key_en_i,
  input  logic [RES_W-1:0] resume_len_i,
  input  logic             bus_act_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             tick_i,
  output logic             osc_en_o,
  output logic             clk_en_o,
  output logic             idle_irq_o,
  output logic [1:0]       state_o
);
  import pwr_pkg::*;

  localparam int CW = $clog2(RES_MAX + 1);

  pwr_state_e    state_q, state_d;
  logic          susp_q;
  logic [KEY_W-1:0] key_s, snap_q;
  logic          act_s;
  logic          res_done;
  logic [CW-1:0] res_len;
  logic          wake_hit;

  pwr_sync #(.W(1)) u_act_sync (
    .clk(clk), .rst_n(rst_n), .d_i(bus_act_i), .q_o(act_s));

  pwr_sync #(.W(KEY_W)) u_key_sync (
    .clk(clk), .rst_n(rst_n), .d_i(key_i), .q_o(key_s));

  assign res_len = CW'(res_ticks(int'(resume_len_i), RES_MIN, RES_MAX, RES_W));

  pwr_idle_det #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk(clk), .rst_n(rst_n), .en_i(state_q == PS_RUN),
    .act_i(act_s), .tick_i(tick_i), .irq_o(idle_irq_o));

  pwr_resume_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .en_i(state_q == PS_WAKE),
    .tick_i(tick_i), .len_i(res_len), .done_o(res_done));

  assign wake_hit = (wake_usb_en_i && act_s) ||
                    (wake_key_en_i && (key_s != snap_q));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN:   if (susp_q)   state_d = PS_SLEEP;
      PS_SLEEP: if (wake_hit) state_d = PS_WAKE;
      PS_WAKE:  if (res_done) state_d = PS_RUN;
      default:                state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RUN;
      susp_q  <= 1'b0;
      snap_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == PS_WAKE && res_done)
        susp_q <= 1'b0;
      else if (susp_set_i)
        susp_q <= 1'b1;
      if (state_q == PS_RUN && state_d == PS_SLEEP)
        snap_q <= key_s;
    end
  end

  assign osc_en_o = (state_q != PS_SLEEP);
  assign clk_en_o = (state_q == PS_RUN);
  assign state_o  = state_q;

  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RUN && susp_q) |=> (state_q == PS_SLEEP));
  a_r5_stay_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SLEEP && !wake_usb_en_i && !wake_key_en_i) |=> (state_q == PS_SLEEP));
  a_r7_wake_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_WAKE && $past(state_q) != PS_WAKE) |-> ($past(state_q) == PS_SLEEP));
  a_r9_req_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == PS_WAKE && state_q == PS_RUN) |-> !susp_q);
  a_r7_clocks_masked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en_o) |-> $past(state_q == PS_WAKE));
endmodule

// File: tb/usb_pwr_seq_bench.sv
module usb_pwr_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic susp_set = 1'b0, usb_en = 1'b0, key_en = 1'b0, bus_act = 1'b0, tick = 1'b0;
  logic [3:0] res_len = '0;
  logic [7:0] key = 8'h5a;
  logic osc_en, clk_en, irq;
  logic [1:0] state;

  int n_cmp = 0, n_bad = 0, irq_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_pwr_seq u_usb_pwr_seq (
    .clk(clk), .rst_n(rst_n), .susp_set_i(susp_set), .wake_usb_en_i(usb_en),
    .wake_key_en_i(key_en), .resume_len_i(res_len), .bus_act_i(bus_act),
    .key_i(key), .tick_i(tick), .osc_en_o(osc_en), .clk_en_o(clk_en),
    .idle_irq_o(irq), .state_o(state));

  always @(negedge clk) if (irq) irq_cnt++;

  function automatic int exp_ticks(input int f);
    return 1 + (f * 19 + 7) / 15;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_tick();
    tick = 1'b1; cyc(1); tick = 1'b0; cyc(2);
  endtask

  task automatic go_sleep();
    susp_set = 1'b1; cyc(1); susp_set = 1'b0; cyc(3);
    check("R2 state", state, 1);
    check("R2 osc_en", osc_en, 0);
    check("R2 clk_en", clk_en, 0);
  endtask

  task automatic bus_burst();
    bus_act = 1'b1; cyc(2); bus_act = 1'b0; cyc(4);
  endtask

  task automatic run_resume(input int f);
    int n;
    n = exp_ticks(f);
    check("R7 osc_en", osc_en, 1);
    check("R7 clk_en", clk_en, 0);
    for (int i = 0; i < n - 1; i++) pulse_tick();
    check("R8 still resuming", state, 2);
    pulse_tick();
    check("R8 running after N ticks", state, 0);
    check("R8 clk_en", clk_en, 1);
    cyc(5);
    check("R9 stays running", state, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int base, f, bit_i;
    void'($urandom(32'd4711));
    cyc(3); rst_n = 1'b1; cyc(2);
    check("R1 state", state, 0);
    check("R1 osc_en", osc_en, 1);
    check("R1 clk_en", clk_en, 1);
    check("R1 irq", irq, 0);

    // R3: idle threshold, single pulse, no self-suspend
    cyc(4);
    base = irq_cnt;
    for (int i = 0; i < 5; i++) pulse_tick();
    check("R3 no irq before threshold", irq_cnt - base, 0);
    pulse_tick();
    check("R3 irq at threshold", irq_cnt - base, 1);
    for (int i = 0; i < 4; i++) pulse_tick();
    check("R3 single pulse", irq_cnt - base, 1);
    check("R3 no self suspend", state, 0);

    // R4: activity restarts the count
    bus_burst();
    base = irq_cnt;
    for (int i = 0; i < 3; i++) pulse_tick();
    bus_burst();
    for (int i = 0; i < 5; i++) pulse_tick();
    check("R4 count restarted", irq_cnt - base, 0);
    pulse_tick();
    check("R4 irq after restart", irq_cnt - base, 1);

    // R5 directed: usb wake disabled, then enabled, f = 0
    res_len = 4'd0; usb_en = 1'b0; key_en = 1'b0;
    go_sleep();
    bus_burst();
    check("R5 ignored when disabled", state, 1);
    usb_en = 1'b1;
    bus_burst();
    check("R5 usb wake", state, 2);
    run_resume(0);

    // R6 directed: key wake, f = 15
    res_len = 4'd15; usb_en = 1'b0; key_en = 1'b1;
    go_sleep();
    bus_burst();
    check("R6 bus ignored, usb disabled", state, 1);
    key = key; cyc(4);
    check("R6 unchanged keys ignored", state, 1);
    key_en = 1'b0; key[3] = ~key[3]; cyc(4);
    check("R6 ignored when disabled", state, 1);
    key_en = 1'b1; cyc(4);
    check("R6 key wake", state, 2);
    run_resume(15);

    // random mix
    for (int it = 0; it < 8; it++) begin
      f = $urandom % 16;
      res_len = 4'(f);
      usb_en = 1'b0; key_en = 1'b0;
      go_sleep();
      if ($urandom % 2 == 0) begin
        usb_en = 1'b1; bus_burst();
        check("R5 random usb wake", state, 2);
      end else begin
        key_en = 1'b1;
        bit_i = $urandom % 8;
        key[bit_i] = ~key[bit_i]; cyc(4);
        check("R6 random key wake", state, 2);
      end
      run_resume(f);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule